// File: doc/BRIEF.md
# Add/Subtract Unit with No-Borrow Carry

This block is the arithmetic core of a small microcoded processor. It adds or subtracts two operands, optionally folding in the stored carry, and produces the result together with carry, zero, negative and overflow flags. Subtraction is carried out as addition of the inverted subtrahend with a carry-in of one. The carry flag after any subtraction is therefore the carry-out of that sum, and it reads as "no borrow": it is set when the unsigned minuend is greater than or equal to the subtrahend.

The result path is purely combinational. A parameter selects whether the four flags leave the block straight from the logic or through a register stage with asynchronous active-low reset. The default is the registered variant, so that the flag outputs can feed the processor's flag latch timing directly. Microcode drives a 2-bit operation code: bit 0 inverts the second operand, and bit 1 takes the carry-in from the stored carry instead of from bit 0.

Top module: `addsub_unit`

## Requirements
- R1: ADD (op_i = 2'b00): result_o = (a_i + b_i) mod 256, and the carry flag is the 9th bit of a_i + b_i.
- R2: ADC (op_i = 2'b10): result_o = (a_i + b_i + carry_i) mod 256, and the carry flag is the 9th bit of that sum.
- R3: SUB (op_i = 2'b01): result_o = (a_i - b_i) mod 256, and the carry flag is 1 exactly when unsigned a_i >= b_i (a clear carry means a borrow occurred).
- R4: SBC (op_i = 2'b11): result_o = a_i + ~b_i + carry_i mod 256, so carry_i = 1 means no pending borrow. The carry flag is the 9th bit of that sum.
- R5: The zero flag is 1 exactly when the 8-bit result is 8'h00.
- R6: The negative flag equals bit 7 of the result.
- R7: The overflow flag is 1 when a_i and the second operand as actually added (b_i for ADD/ADC, ~b_i for SUB/SBC) share bit 7 and the result's bit 7 differs from it.
- R8: With REG_FLAGS = 1 (default), the flag outputs show the flags of the operands present at the previous rising clock edge. While rst_ni is low, all four flag outputs are 0.
- R9: For ADD and SUB the value of carry_i has no effect on the result or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | First operand (minuend) |
| b_i | input | 8 | Second operand (subtrahend) |
| op_i | input | 2 | Operation: 00 ADD, 01 SUB, 10 ADC, 11 SBC |
| carry_i | input | 1 | Stored carry flag |
| result_o | output | 8 | Sum or difference, combinational |
| carry_o | output | 1 | Carry flag; after a subtraction, 1 = no borrow |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
On every cycle, the assertions check four things. The carry-in is fixed for ADD and SUB. The subtraction carry matches the unsigned compare a >= b. The ADD carry matches a wide sum. The registered zero, negative and overflow flags follow the previous cycle's result and operands. The exact arithmetic for all four operations, the corner differences 0-1, 5-5 and 0x80-1, the borrow chaining through SBC and the reset values of the flags can only be shown by the bench's directed scenarios, which compare the outputs with an independent reference model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_ADC = 2'b10,
    OP_SBC = 2'b11
  } as_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } as_flags_t;
endpackage

// File: rtl/as_operand.sv
module as_operand #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         carry_i,
  output logic [W-1:0] bm_o,
  output logic         cin_o
);
  // op[0]: invert second operand; op[1]: take carry-in from stored carry
  assign bm_o  = op_i[0] ? ~b_i : b_i;
  assign cin_o = op_i[1] ? carry_i : op_i[0];

  p_cin_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[1] == 1'b0) |-> (cin_o == op_i[0] && $stable(cin_o) || cin_o == op_i[0]));
endmodule

// File: rtl/as_adder.sv
module as_adder #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] bm_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] wide;

  assign wide   = {1'b0, a_i} + {1'b0, bm_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  assign ovf_o  = (a_i[W-1] == bm_i[W-1]) && (sum_o[W-1] != a_i[W-1]);

  // R1: zero carry-in never yields sum below operand a (wrap implies carry)
  p_wrap_carry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cin_i && sum_o < a_i) |-> cout_o);
endmodule

// File: rtl/as_flags.sv
module as_flags #(
  parameter int unsigned W         = 8,
  parameter bit          REG_FLAGS = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [W-1:0]           sum_i,
  input  logic                   cout_i,
  input  logic                   ovf_i,
  output addsub_pkg::as_flags_t  flags_o
);
  import addsub_pkg::*;

  as_flags_t flags_d;

  always_comb begin
    flags_d.c = cout_i;
    flags_d.z = (sum_i == '0);
    flags_d.n = sum_i[W-1];
    flags_d.v = ovf_i;
  end

  if (REG_FLAGS) begin : g_reg
    as_flags_t flags_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= flags_d;
    end
    assign flags_o = flags_q;

    p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_i == '0) |=> flags_o.z);
    p_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (flags_o.n == $past(sum_i[W-1])));
  end else begin : g_comb
    assign flags_o = flags_d;
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
  parameter int unsigned W         = addsub_pkg::DW,
  parameter bit          REG_FLAGS = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);
  import addsub_pkg::*;

  logic [W-1:0] bm;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;
  as_flags_t    flags;

  as_operand #(.W(W)) u_opnd (
    .clk_i, .rst_ni, .b_i, .op_i, .carry_i,
    .bm_o(bm), .cin_o(cin)
  );

  as_adder #(.W(W)) u_add (
    .clk_i, .rst_ni, .a_i, .bm_i(bm), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  as_flags #(.W(W), .REG_FLAGS(REG_FLAGS)) u_flg (
    .clk_i, .rst_ni, .sum_i(sum), .cout_i(cout), .ovf_i(ovf),
    .flags_o(flags)
  );

  assign result_o = sum;
  assign carry_o  = flags.c;
  assign zero_o   = flags.z;
  assign neg_o    = flags.n;
  assign ovf_o    = flags.v;

  // R3: subtract carry is the no-borrow compare
  p_sub_noborrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SUB) |-> (cout == (a_i >= b_i)));
  // R1: plain add carry is the wide-sum top bit
  p_add_carry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD) |-> (cout == (({1'b0, a_i} + {1'b0, b_i}) > {1'b0, {W{1'b1}}})));

  if (REG_FLAGS) begin : g_chk
    // R7: same-sign add whose result flips sign raises overflow next cycle
    p_ovf_add_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((op_i == OP_ADD) && (a_i[W-1] == b_i[W-1]) && (result_o[W-1] != a_i[W-1]))
      |=> ovf_o);
    // R8: carry output is last cycle's carry-out
    p_carry_reg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (carry_o == $past(cout)));
  end
endmodule

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [1:0] op = '0;
  logic       cy = 1'b0;
  logic [7:0] res;
  logic       co, zo, no, vo;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addsub_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op), .carry_i(cy),
    .result_o(res), .carry_o(co), .zero_o(zo), .neg_o(no), .ovf_o(vo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference: sub-type ops add inverted b; carry-in per op
  task automatic run(input logic [1:0] o, input logic [7:0] x, input logic [7:0] y,
                     input logic c, input string req);
    logic [7:0] ym;
    logic       ci;
    logic [8:0] w;
    logic       v;
    ym = o[0] ? ~y : y;
    ci = o[1] ? c : o[0];
    w  = {1'b0, x} + {1'b0, ym} + {8'd0, ci};
    v  = (x[7] == ym[7]) && (w[7] != x[7]);
    @(negedge clk);
    op = o; a = x; b = y; cy = c;
    #1;
    chk(res == w[7:0], {req, " result"}, res, w[7:0]);
    @(posedge clk);
    #1;
    chk(co == w[8], {req, " carry"}, co, w[8]);
    chk(zo == (w[7:0] == 8'h00), "R5 zero", zo, w[7:0] == 8'h00);
    chk(no == w[7], "R6 neg", no, w[7]);
    chk(vo == v, "R7 ovf", vo, v);
  endtask

  task automatic t_reset;
    @(negedge clk);
    a = 8'hff; b = 8'h01; op = 2'b00; cy = 1'b1;
    #1;
    chk({co, zo, no, vo} == 4'b0000, "R8 reset flags", {co, zo, no, vo}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_add;
    run(2'b00, 8'h12, 8'h34, 1'b1, "R1");
    run(2'b00, 8'hff, 8'h01, 1'b0, "R1");
    run(2'b00, 8'h7f, 8'h01, 1'b0, "R1");
    run(2'b00, 8'h80, 8'h80, 1'b0, "R1");
  endtask

  task automatic t_adc;
    run(2'b10, 8'hfe, 8'h01, 1'b1, "R2");
    run(2'b10, 8'h10, 8'h20, 1'b1, "R2");
    run(2'b10, 8'h10, 8'h20, 1'b0, "R2");
  endtask

  task automatic t_sub_corners;
    run(2'b01, 8'h00, 8'h01, 1'b1, "R3 0-1");
    chk(co == 1'b0 && res == 8'hff, "R3 0-1 borrow", {co, res}, 9'h0ff);
    run(2'b01, 8'h05, 8'h05, 1'b0, "R3 5-5");
    chk(co == 1'b1 && zo == 1'b1, "R3 5-5 noborrow", {co, zo}, 2'b11);
    run(2'b01, 8'h80, 8'h01, 1'b0, "R3 80-1");
    chk(vo == 1'b1 && res == 8'h7f, "R7 80-1 ovf", {vo, res}, 9'h17f);
  endtask

  task automatic t_sbc;
    run(2'b11, 8'h05, 8'h05, 1'b0, "R4");
    chk(res == 8'hff && co == 1'b0, "R4 borrow in", {co, res}, 9'h0ff);
    run(2'b11, 8'h05, 8'h05, 1'b1, "R4");
    run(2'b11, 8'h00, 8'h00, 1'b0, "R4");
  endtask

  task automatic t_ignore;
    logic [7:0] r0; logic [3:0] f0;
    foreach (r0[i]) ;
    for (int k = 0; k < 2; k++) begin
      logic [1:0] o;
      o = (k == 0) ? 2'b00 : 2'b01;
      run(o, 8'h3c, 8'h5a, 1'b0, "R9");
      r0 = res; f0 = {co, zo, no, vo};
      run(o, 8'h3c, 8'h5a, 1'b1, "R9");
      chk(res == r0 && {co, zo, no, vo} == f0, "R9 carry_i ignored",
          {res, co, zo, no, vo}, {r0, f0});
    end
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 4; o++)
      for (int x = 0; x < 256; x += 15)
        for (int y = 0; y < 256; y += 17)
          for (int c = 0; c < 2; c++)
            run(o[1:0], x[7:0], y[7:0], c[0], "R1R2R3R4 sweep");
  endtask

  initial begin
    t_reset();
    t_add();
    t_adc();
    t_sub_corners();
    t_sbc();
    t_ignore();
    t_sweep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule